// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block serialises one low-speed USB packet onto the D+/D- pair. On a start strobe it takes the bus by enabling its drivers with the lines already at the idle J level and holds J for one bit period. It then sends a fixed synchronisation byte followed by the caller's bytes, least significant bit first. Each bit is NRZI encoded and a stuffed bit is inserted after every run of six ones. After the last bit it signals end of packet, drives J for a single clock and releases the lines.

The caller supplies the total packet length (synchronisation byte included) and answers byte requests on a simple pull interface. Each request arrives one bit time before the byte is needed, so the bit clock never stalls. Two side effects finish each packet. A pending device address is made current, but only when the packet carried data and not when it was a bare handshake. A one-clock pulse also clears any receive-start event that the block's own transmission may have raised.

Top module: `usb_ls_tx`

## Requirements
- R1: In the clock after an accepted start, oe_o is 1 and the lines show J (dp_o=0, dm_o=1). J is held for BIT_CLKS clocks before the first bit.
- R2: The first byte on the wire is 0x80, sent least significant bit first. It is followed by len_i-1 bytes taken from byte_i in request order. len_i counts the whole packet; values below 2 act as 2 and values above MAX_LEN act as MAX_LEN.
- R3: Each bit occupies exactly BIT_CLKS clocks. A 0 bit toggles the line between J and K (K is dp_o=1, dm_o=0), and a 1 bit keeps the previous level.
- R4: After six consecutive 1 bits, one extra toggle is inserted before anything else is sent. The run count carries across byte boundaries and also applies after the final data bit.
- R5: byte_req_o is a one-clock pulse. It is raised in the first clock that bit 6 of the preceding byte is on the line. There is exactly one pulse per data byte. byte_i must present that byte from the clock after the pulse until the next bit boundary.
- R6: Right after the final bit period (stuffed bit included), both lines are driven low with oe_o=1 for exactly SE0_CLKS clocks.
- R7: The SE0 is followed by exactly one clock of J with oe_o=1. Then oe_o falls, and dp_o and dm_o are both 0 while the lines are released.
- R8: busy_o is 1 from the clock after an accepted start until the release clock. done_o pulses for one clock in the release clock.
- R9: start_i is ignored while busy_o is 1.
- R10: dev_addr_o takes the value of new_addr_i in the first SE0 clock, but only when the effective length exceeds 2. It never changes in any other clock.
- R11: rx_evt_clr_o is a one-clock pulse in the first SE0 clock of every packet.
- R12: After reset, oe_o, dp_o, dm_o, busy_o, done_o, byte_req_o and rx_evt_clr_o are 0, and dev_addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| len_i | input | LEN_W | Packet length in bytes, sync included |
| byte_i | input | 8 | Next packet byte, answered after a request |
| byte_req_o | output | 1 | Request pulse for the next byte |
| new_addr_i | input | ADDR_W | Pending device address |
| dev_addr_o | output | ADDR_W | Current device address |
| dp_o | output | 1 | D+ drive value |
| dm_o | output | 1 | D- drive value |
| oe_o | output | 1 | Line driver enable |
| busy_o | output | 1 | Transmission in progress |
| done_o | output | 1 | One-clock pulse when the bus is released |
| rx_evt_clr_o | output | 1 | Clears a receive-start event caused by this transmission |

## Verification
The hardest cases to reach are stuffing decisions that fall on a byte seam or after the final data bit. These depend on the trailing ones of the sync byte and on the exact bit content that follows. The stimulus creates both by choice of byte values: 0xFF bytes right after the sync byte make the run cross a byte boundary, and a lone 0xFC handshake byte ends on six ones. Each packet is recorded clock by clock and compared with a line waveform that the bench builds independently from the bytes.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PREP,
      ST_DATA,
      ST_SE0,
      ST_JDRV
   } tx_state_e;

   localparam logic [7:0] SYNC_BYTE = 8'h80;
   localparam int         STUFF_RUN = 6;

endpackage

// File: rtl/usb_ls_tx_timer.sv
module usb_ls_tx_timer #(
   parameter int BIT_CLKS = 11,
   parameter int SE0_CLKS = 22
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic bit_end_o,
   output logic se0_end_o
);
   localparam int CNT_MAX = (SE0_CLKS > BIT_CLKS) ? SE0_CLKS : BIT_CLKS;
   localparam int CW      = $clog2(CNT_MAX + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   assign bit_end_o = (cnt_q == CW'(BIT_CLKS - 1));
   assign se0_end_o = (cnt_q == CW'(SE0_CLKS - 1));
endmodule

// File: rtl/usb_ls_tx_shifter.sv
module usb_ls_tx_shifter
   import usb_ls_tx_pkg::*;
#(
   parameter int LEN_W   = 4,
   parameter int MAX_LEN = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             step_i,
   input  logic [7:0]       byte_i,
   output logic             bit_o,
   output logic             empty_o,
   output logic             long_o,
   output logic             req_o
);
   localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(2);
   localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_LEN);

   logic [LEN_W-1:0] len_c;
   logic [7:0]       sh_q;
   logic [2:0]       idx_q;
   logic [LEN_W-1:0] left_q;
   logic             empty_q, long_q, req_q;

   always_comb begin
      if (len_i < LEN_LO)      len_c = LEN_LO;
      else if (len_i > LEN_HI) len_c = LEN_HI;
      else                     len_c = len_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         idx_q   <= '0;
         left_q  <= '0;
         empty_q <= 1'b0;
         long_q  <= 1'b0;
         req_q   <= 1'b0;
      end else begin
         req_q <= 1'b0;
         if (init_i) begin
            sh_q    <= SYNC_BYTE;
            idx_q   <= '0;
            left_q  <= len_c - 1'b1;
            empty_q <= 1'b0;
            long_q  <= (len_c > LEN_LO);
         end else if (step_i) begin
            if (idx_q == 3'd7) begin
               if (left_q != '0) begin
                  sh_q   <= byte_i;
                  left_q <= left_q - 1'b1;
                  idx_q  <= '0;
               end else begin
                  empty_q <= 1'b1;
               end
            end else begin
               sh_q  <= {1'b0, sh_q[7:1]};
               idx_q <= idx_q + 1'b1;
            end
            req_q <= (idx_q == 3'd6) && (left_q != '0);
         end
      end
   end

   assign bit_o   = sh_q[0];
   assign empty_o = empty_q;
   assign long_o  = long_q;
   assign req_o   = req_q;
endmodule

// File: rtl/usb_ls_tx_line.sv
module usb_ls_tx_line
   import usb_ls_tx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic init_i,
   input  logic emit_i,
   input  logic bit_i,
   output logic lvl_o,
   output logic stuff_o
);
   localparam int RW = $clog2(STUFF_RUN + 1);

   logic [RW-1:0] run_q;
   logic          lvl_q;

   assign stuff_o = (run_q == RW'(STUFF_RUN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         lvl_q <= 1'b1;
      end else if (init_i) begin
         run_q <= '0;
         lvl_q <= 1'b1;
      end else if (emit_i) begin
         if (stuff_o || !bit_i) begin
            lvl_q <= ~lvl_q;
            run_q <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   assign lvl_o = lvl_q;
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
   import usb_ls_tx_pkg::*;
#(
   parameter int BIT_CLKS = 11,
   parameter int SE0_CLKS = 22,
   parameter int LEN_W    = 4,
   parameter int MAX_LEN  = 12,
   parameter int ADDR_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [7:0]        byte_i,
   output logic              byte_req_o,
   input  logic [ADDR_W-1:0] new_addr_i,
   output logic [ADDR_W-1:0] dev_addr_o,
   output logic              dp_o,
   output logic              dm_o,
   output logic              oe_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              rx_evt_clr_o
);
   if (BIT_CLKS < 4) begin : g_bad_bit
      $error("usb_ls_tx: BIT_CLKS must be at least 4");
   end
   if (SE0_CLKS <= BIT_CLKS || SE0_CLKS > 3 * BIT_CLKS) begin : g_bad_se0
      $error("usb_ls_tx: SE0_CLKS must lie between one and three bit periods");
   end
   if (MAX_LEN < 2 || MAX_LEN >= (1 << LEN_W)) begin : g_bad_len
      $error("usb_ls_tx: MAX_LEN must fit LEN_W and be at least 2");
   end

   tx_state_e         state_q, state_d;
   logic              bit_end, se0_end, tmr_load;
   logic              accept, boundary, go_se0, emit, step;
   logic              stuff, lvl, cur_bit, empty, long_pkt;
   logic              done_q, clr_q;
   logic [ADDR_W-1:0] addr_q;

   assign accept   = (state_q == ST_IDLE) && start_i;
   assign boundary = ((state_q == ST_PREP) || (state_q == ST_DATA)) && bit_end;
   assign go_se0   = boundary && (state_q == ST_DATA) && !stuff && empty;
   assign emit     = boundary && !go_se0;
   assign step     = emit && !stuff;
   assign tmr_load = (state_q == ST_IDLE) || boundary ||
                     ((state_q == ST_SE0) && se0_end);

   usb_ls_tx_timer #(
      .BIT_CLKS (BIT_CLKS),
      .SE0_CLKS (SE0_CLKS)
   ) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (tmr_load),
      .bit_end_o (bit_end),
      .se0_end_o (se0_end)
   );

   usb_ls_tx_shifter #(
      .LEN_W   (LEN_W),
      .MAX_LEN (MAX_LEN)
   ) i_shifter (
      .clk     (clk),
      .rst_n   (rst_n),
      .init_i  (accept),
      .len_i   (len_i),
      .step_i  (step),
      .byte_i  (byte_i),
      .bit_o   (cur_bit),
      .empty_o (empty),
      .long_o  (long_pkt),
      .req_o   (byte_req_o)
   );

   usb_ls_tx_line i_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .init_i  (accept),
      .emit_i  (emit),
      .bit_i   (cur_bit),
      .lvl_o   (lvl),
      .stuff_o (stuff)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (accept)   state_d = ST_PREP;
         ST_PREP: if (boundary) state_d = ST_DATA;
         ST_DATA: if (go_se0)   state_d = ST_SE0;
         ST_SE0:  if (se0_end)  state_d = ST_JDRV;
         ST_JDRV:               state_d = ST_IDLE;
         default:               state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         clr_q   <= 1'b0;
         addr_q  <= '0;
      end else begin
         state_q <= state_d;
         done_q  <= (state_q == ST_JDRV);
         clr_q   <= go_se0;
         if (go_se0 && long_pkt) addr_q <= new_addr_i;
      end
   end

   always_comb begin
      unique case (state_q)
         ST_PREP, ST_DATA: begin oe_o = 1'b1; dp_o = ~lvl; dm_o = lvl;  end
         ST_SE0:           begin oe_o = 1'b1; dp_o = 1'b0; dm_o = 1'b0; end
         ST_JDRV:          begin oe_o = 1'b1; dp_o = 1'b0; dm_o = 1'b1; end
         default:          begin oe_o = 1'b0; dp_o = 1'b0; dm_o = 1'b0; end
      endcase
   end

   assign busy_o       = (state_q != ST_IDLE);
   assign done_o       = done_q;
   assign rx_evt_clr_o = clr_q;
   assign dev_addr_o   = addr_q;
endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk #(
   parameter int SE0_CLKS = 22,
   parameter int ADDR_W   = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              byte_req_o,
   input logic [ADDR_W-1:0] dev_addr_o,
   input logic              dp_o,
   input logic              dm_o,
   input logic              oe_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              rx_evt_clr_o
);
   localparam int SW = $clog2(SE0_CLKS + 2);

   logic          in_se0;
   logic [SW-1:0] se0_run;

   assign in_se0 = oe_o && !dp_o && !dm_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  se0_run <= '0;
      else if (in_se0)             se0_run <= se0_run + 1'b1;
      else                         se0_run <= '0;
   end

   a_r1_start_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (oe_o && dm_o && !dp_o));

   a_r6_se0_len: assert property (@(posedge clk) disable iff (!rst_n)
      (se0_run != '0 && !in_se0) |-> (se0_run == SW'(SE0_CLKS)));

   a_r7_release_after_j: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_o && dm_o && !dp_o && $past(in_se0)) |=> !oe_o);

   a_r7_released_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_o |-> (!dp_o && !dm_o));

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r8_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $fell(busy_o));

   a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      byte_req_o |=> !byte_req_o);

   a_r11_clr_in_se0: assert property (@(posedge clk) disable iff (!rst_n)
      rx_evt_clr_o |-> (in_se0 && !$past(in_se0)));

   a_r10_addr_only_at_eop: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dev_addr_o) |-> rx_evt_clr_o);
endmodule

bind usb_ls_tx usb_ls_tx_chk #(
   .SE0_CLKS (SE0_CLKS),
   .ADDR_W   (ADDR_W)
) i_chk (.*);

// File: tb/test_usb_ls_tx.sv
module test_usb_ls_tx;
   localparam int BIT  = 11;
   localparam int SE0  = 22;
   localparam int TMAX = 4096;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [3:0] len_i = '0;
   logic [7:0] byte_i;
   logic       byte_req_o;
   logic [6:0] new_addr_i = '0;
   logic [6:0] dev_addr_o;
   logic       dp_o, dm_o, oe_o, busy_o, done_o, rx_evt_clr_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int reqn = 0;
   int base = 0;

   logic [7:0] mem [0:15];
   logic       exp_lvl [0:255];
   int         nb;
   logic [2:0] tr  [0:TMAX-1];
   logic       trb [0:TMAX-1];
   logic       trd [0:TMAX-1];
   logic       trc [0:TMAX-1];
   logic [6:0] tra [0:TMAX-1];
   int         ntr;

   always #2.5 clk = ~clk;

   assign byte_i = mem[4'(reqn - base)];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (byte_req_o) reqn <= reqn + 1;
   end

   usb_ls_tx #(
      .BIT_CLKS (BIT),
      .SE0_CLKS (SE0)
   ) i_usb_ls_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .len_i        (len_i),
      .byte_i       (byte_i),
      .byte_req_o   (byte_req_o),
      .new_addr_i   (new_addr_i),
      .dev_addr_o   (dev_addr_o),
      .dp_o         (dp_o),
      .dm_o         (dm_o),
      .oe_o         (oe_o),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .rx_evt_clr_o (rx_evt_clr_o)
   );

   task automatic chk(input string req, input bit ok, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic build_exp(input int ndata);
      logic lvl;
      int   run;
      logic [7:0] b;
      lvl = 1'b1; run = 0; nb = 0;
      for (int i = 0; i <= ndata; i++) begin
         b = (i == 0) ? 8'h80 : mem[i];
         for (int j = 0; j < 8; j++) begin
            if (!b[j]) begin lvl = ~lvl; run = 0; end
            else run++;
            exp_lvl[nb] = lvl; nb++;
            if (run == 6) begin lvl = ~lvl; exp_lvl[nb] = lvl; nb++; run = 0; end
         end
      end
   endtask

   // Runs one packet, records every clock and checks it against the model.
   task automatic packet(input logic [3:0] len, input int ndata, input string dtag,
                         input int glitch, input logic [6:0] naddr);
      logic [6:0] old_addr, exp_addr;
      int t, rel, se0_at, seg;
      int bad [0:3];
      int fa  [0:3];
      int fe  [0:3];
      int bad_bd, bad_c;
      logic [2:0] e;
      bit fin;
      build_exp(ndata);
      old_addr = dev_addr_o;
      exp_addr = (ndata >= 2) ? naddr : old_addr;
      new_addr_i = naddr;
      base = reqn;
      len_i = len;
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      t = 0; fin = 0;
      while (!fin && t < TMAX) begin
         tr[t]  = {oe_o, dp_o, dm_o};
         trb[t] = busy_o; trd[t] = done_o; trc[t] = rx_evt_clr_o; tra[t] = dev_addr_o;
         if (!oe_o) fin = 1;
         start_i = (t == glitch);
         t++;
         @(negedge clk);
      end
      start_i = 1'b0;
      ntr = t;
      se0_at = BIT * (nb + 1);
      rel = se0_at + SE0 + 1;
      chk("R6/R7 frame length", ntr == rel + 1, ntr, rel + 1);
      for (int s = 0; s < 4; s++) begin bad[s] = 0; fa[s] = 0; fe[s] = 0; end
      bad_bd = 0; bad_c = 0;
      for (int i = 0; i < ntr && i <= rel; i++) begin
         if (i < BIT) begin e = 3'b101; seg = 0; end
         else if (i < se0_at) begin
            e = exp_lvl[i / BIT - 1] ? 3'b101 : 3'b110; seg = 1;
         end
         else if (i < se0_at + SE0) begin e = 3'b100; seg = 2; end
         else if (i < rel) begin e = 3'b101; seg = 3; end
         else begin e = 3'b000; seg = 3; end
         if (tr[i] != e) begin
            if (bad[seg] == 0) begin fa[seg] = int'(tr[i]); fe[seg] = int'(e); end
            bad[seg]++;
         end
         if (trb[i] != (i < rel) || trd[i] != (i == rel)) bad_bd++;
         if (trc[i] != (i == se0_at)) bad_c++;
      end
      chk("R1 J before first bit", bad[0] == 0, fa[0], fe[0]);
      chk({dtag, " line bits"}, bad[1] == 0, fa[1], fe[1]);
      chk("R6 SE0", bad[2] == 0, fa[2], fe[2]);
      chk("R7 J then release", bad[3] == 0, fa[3], fe[3]);
      chk("R8 busy/done", bad_bd == 0, bad_bd, 0);
      chk("R11 clear pulse", bad_c == 0, bad_c, 0);
      chk("R5 request count", (reqn - base) == ndata, reqn - base, ndata);
      chk("R10 address before EOP", tra[se0_at - 1] == old_addr,
          int'(tra[se0_at - 1]), int'(old_addr));
      chk("R10 address after EOP", dev_addr_o == exp_addr, int'(dev_addr_o), int'(exp_addr));
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R12 oe", oe_o == 1'b0, oe_o, 0);
      chk("R12 lines", {dp_o, dm_o} == 2'b00, {dp_o, dm_o}, 0);
      chk("R12 busy/done", {busy_o, done_o} == 2'b00, {busy_o, done_o}, 0);
      chk("R12 req/clr", {byte_req_o, rx_evt_clr_o} == 2'b00, {byte_req_o, rx_evt_clr_o}, 0);
      chk("R12 address", dev_addr_o == 7'd0, int'(dev_addr_o), 0);
   endtask

   task automatic t_handshake;
      mem[1] = 8'hD2;
      packet(4'd2, 1, "R2/R3", -1, 7'h15);
   endtask

   task automatic t_data;
      mem[1] = 8'hC3; mem[2] = 8'h5A; mem[3] = 8'h00;
      packet(4'd4, 3, "R2/R3", -1, 7'h2B);
   endtask

   task automatic t_stuff_cross;
      mem[1] = 8'hFF; mem[2] = 8'hFF; mem[3] = 8'h01;
      packet(4'd4, 3, "R4 cross-byte", -1, 7'h33);
   endtask

   task automatic t_stuff_tail;
      mem[1] = 8'hFC;
      packet(4'd2, 1, "R4 tail", -1, 7'h7F);
   endtask

   task automatic t_clamp_hi;
      for (int i = 1; i < 16; i++) mem[i] = 8'((i * 37) ^ 8'h6C);
      packet(4'd15, 11, "R2 clamp high", -1, 7'h41);
   endtask

   task automatic t_clamp_lo;
      mem[1] = 8'h4B;
      packet(4'd0, 1, "R2 clamp low", -1, 7'h0E);
   endtask

   task automatic t_busy_start;
      mem[1] = 8'h96; mem[2] = 8'h3C;
      packet(4'd3, 2, "R9 start while busy", 60, 7'h55);
      chk("R9 stays idle after", busy_o == 1'b0, busy_o, 0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_handshake();
      t_data();
      t_stuff_cross();
      t_stuff_tail();
      t_clamp_hi();
      t_clamp_lo();
      t_busy_start();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule